// File: doc/BRIEF.md
# Staggered Power-Domain Enable Sequencer

This block brings a chain of switchable power domains up one at a time so that the supply never sees the inrush of all of them together. The chain has a fixed dependency order. The reference and main regulator stage comes first. The digital and low-leakage regulator pair follows. Then come the memory banks from bank 0 upward, then the radio domain, and the non-volatile memory domain is last. A stage is switched on only when the stage before it has either reported ready on its handshake input or, for stages without a ready input, held its enable for a fixed settle count. The sequence runs after reset and again after every wake from deep sleep.

When software requests one of the two deep sleep modes, the sequencer turns the domains off one per clock in reverse order. There are two exceptions. A memory bank selected in the retention mask stays powered and raises its retention flag. The radio domain stays on if the radio is not reporting sleep at the moment its turn comes. Domains that stay on through sleep are passed over on the next wake. Requests for lighter sleep modes do not change any enable. A deep-sleep request made during power-up waits until the chain is complete.

Top module: `pwr_chain_seq`

## Requirements
- R1: While `rst` is high, all of `dom_en`, `bank_ret`, `llreg_ok` and `chain_done` are 0. At the first clock edge after reset is released, only `dom_en[0]` turns on.
- R2: `dom_en` bit k is stage k. Bit 0 is the reference stage, bit 1 the regulator pair, bits 2 to NB+1 are banks 0 to NB-1, bit NB+2 is the radio and bit NB+3 is the non-volatile memory. At most one bit turns on per clock, and bit k turns on only while bit k-1 is already on.
- R3: A stage whose `RDY_MASK` bit is 1 completes at the first clock edge at which it is enabled and its `stage_rdy` bit is sampled high. The next stage turns on one edge later.
- R4: A stage whose `RDY_MASK` bit is 0 completes SETTLE edges after its enable rose. The next stage's enable therefore rises SETTLE+1 edges after its own.
- R5: `llreg_ok` rises when stage 1 completes and falls at the edge that turns stage 1 off.
- R6: `chain_done` rises at the edge where the last stage completes. While it is high, every `dom_en` bit is 1. It falls at the same edge that turns off the last stage.
- R7: A `sleep_req` pulse with `sleep_mode` 3'b010 (power-down) or 3'b011 (power-save), sampled while the chain is complete, turns off stage NB+3 at that same edge. It then turns off one lower stage per edge down to stage 0.
- R8: A `sleep_req` with any other `sleep_mode` code leaves every output unchanged.
- R9: A deep-sleep request sampled during power-up is held. The power-down starts at the first edge after `chain_done` rises.
- R10: `ret_mask` is sampled with the accepted deep-sleep request. A selected bank keeps its enable, and its `bank_ret` bit rises at that bank's turn in the power-down. On wake the bank is passed over in one edge without a wait. All `bank_ret` bits clear when `chain_done` rises.
- R11: At the radio's turn in the power-down, the radio is turned off only if `radio_sleep` is 1. Otherwise it stays on and is passed over on the next wake.
- R12: A `wake` pulse while everything that can be off is off restarts the chain from stage 0. A `wake` during the power-down is remembered, and the chain restarts one edge after the power-down ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| sleep_req | input | 1 | One-cycle sleep request strobe |
| sleep_mode | input | 3 | Sleep mode code sampled with the strobe |
| wake | input | 1 | One-cycle wake event |
| stage_rdy | input | NB+4 | Per-stage ready handshake |
| ret_mask | input | NB | Banks to keep in retention during deep sleep |
| radio_sleep | input | 1 | Radio reports it is asleep |
| dom_en | output | NB+4 | Per-domain power switch enable |
| bank_ret | output | NB | Per-bank retention switch |
| llreg_ok | output | 1 | Low-leakage regulator stage complete |
| chain_done | output | 1 | Whole chain powered |

## Verification
The bench goes after the handoff timing between stages. A design that advanced on a ready level seen before its own enable, or that miscounted the settle window, would turn on the next domain one cycle early or late. It also issues deep-sleep requests during power-up and wake events during power-down. A design that dropped a held request would never power down, and one that dropped a held wake would stay off. Retention masks and an awake radio test the skip rules: a wrong design would leave a kept bank off after wake, would stall waiting on a domain that was never switched off, or would shut down the radio while it is still active. Light-sleep codes are sent to confirm that nothing moves.

// File: rtl/pwr_chain_pkg.sv
package pwr_chain_pkg;

  typedef enum logic [1:0] {
    PS_UP    = 2'd0,
    PS_DONE  = 2'd1,
    PS_DOWN  = 2'd2,
    PS_SLEEP = 2'd3
  } pseq_state_e;

  localparam logic [2:0] MODE_PWR_DOWN = 3'b010;
  localparam logic [2:0] MODE_PWR_SAVE = 3'b011;

  function automatic logic is_deep(input logic [2:0] mode);
    return (mode == MODE_PWR_DOWN) || (mode == MODE_PWR_SAVE);
  endfunction

endpackage

// File: rtl/pwr_chain_settle.sv
module pwr_chain_settle #(
  parameter int SETTLE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic step,
  output logic expired
);
  localparam int TW = $clog2(SETTLE + 1);

  logic [TW-1:0] cnt;

  assign expired = (cnt == TW'(SETTLE - 1));

  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (load)             cnt <= '0;
    else if (step && !expired) cnt <= cnt + TW'(1);
  end
endmodule

// File: rtl/pwr_chain_keep.sv
module pwr_chain_keep #(
  parameter int NB = 4,
  parameter int IW = 3
) (
  input  logic [IW-1:0] idx,
  input  logic [NB-1:0] retq,
  input  logic          radio_sleep,
  output logic [NB-1:0] bank_hit,
  output logic          keep
);
  localparam int RADIO = NB + 2;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign bank_hit[b] = (idx == IW'(b + 2));
  end

  assign keep = (|(bank_hit & retq)) || ((idx == IW'(RADIO)) && !radio_sleep);
endmodule

// File: rtl/pwr_chain_req.sv
module pwr_chain_req
  import pwr_chain_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  pseq_state_e state,
  input  logic        sleep_req,
  input  logic [2:0]  sleep_mode,
  input  logic        wake,
  output logic        go_down,
  output logic        go_up
);
  logic sleep_pend, wake_pend, deep_req;

  assign deep_req = sleep_req && is_deep(sleep_mode);
  assign go_down  = (state == PS_DONE)  && (sleep_pend || deep_req);
  assign go_up    = (state == PS_SLEEP) && (wake_pend || wake);

  always_ff @(posedge clk) begin
    if (rst) begin
      sleep_pend <= 1'b0;
      wake_pend  <= 1'b0;
    end else begin
      if (go_down)                           sleep_pend <= 1'b0;
      else if (state == PS_UP && deep_req)   sleep_pend <= 1'b1;
      if (go_up)                             wake_pend  <= 1'b0;
      else if (state == PS_DOWN && wake)     wake_pend  <= 1'b1;
    end
  end
endmodule

// File: rtl/pwr_chain_seq.sv
module pwr_chain_seq
  import pwr_chain_pkg::*;
#(
  parameter int              NB       = 4,
  parameter int              SETTLE   = 4,
  parameter logic [NB+3:0]   RDY_MASK = {2'b11, {NB{1'b0}}, 2'b11}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sleep_req,
  input  logic [2:0]    sleep_mode,
  input  logic          wake,
  input  logic [NB+3:0] stage_rdy,
  input  logic [NB-1:0] ret_mask,
  input  logic          radio_sleep,
  output logic [NB+3:0] dom_en,
  output logic [NB-1:0] bank_ret,
  output logic          llreg_ok,
  output logic          chain_done
);
  localparam int NS   = NB + 4;
  localparam int IW   = $clog2(NS);
  localparam int LAST = NS - 1;
  localparam int LLS  = 1;

  pseq_state_e   state;
  logic [IW-1:0] idx;
  logic [NS-1:0] en_q, skip_q;
  logic [NB-1:0] retq, bret_q, bank_hit;
  logic          ll_q, done_q;
  logic          go_down, go_up, keep, tmr_exp;
  logic          in_up, cur_skip, cur_on, stage_ok, load, step, advance;

  assign in_up    = (state == PS_UP);
  assign cur_skip = skip_q[idx];
  assign cur_on   = en_q[idx];
  assign stage_ok = RDY_MASK[idx] ? stage_rdy[idx] : tmr_exp;
  assign load     = in_up && !cur_skip && !cur_on;
  assign step     = in_up && !cur_skip && cur_on;
  assign advance  = in_up && (cur_skip || (cur_on && stage_ok));

  pwr_chain_settle #(.SETTLE(SETTLE)) u_settle (
    .clk(clk), .rst(rst), .load(load), .step(step), .expired(tmr_exp)
  );

  pwr_chain_keep #(.NB(NB), .IW(IW)) u_keep (
    .idx(idx), .retq(retq), .radio_sleep(radio_sleep),
    .bank_hit(bank_hit), .keep(keep)
  );

  pwr_chain_req u_req (
    .clk(clk), .rst(rst), .state(state), .sleep_req(sleep_req),
    .sleep_mode(sleep_mode), .wake(wake), .go_down(go_down), .go_up(go_up)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= PS_UP;
      idx    <= '0;
      en_q   <= '0;
      skip_q <= '0;
      retq   <= '0;
      bret_q <= '0;
      ll_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      case (state)
        PS_UP: begin
          if (load) en_q[idx] <= 1'b1;
          if (advance) begin
            if (idx == IW'(LLS)) ll_q <= 1'b1;
            if (idx == IW'(LAST)) begin
              state  <= PS_DONE;
              done_q <= 1'b1;
              bret_q <= '0;
            end else begin
              idx <= idx + IW'(1);
            end
          end
        end
        PS_DONE: begin
          if (go_down) begin
            en_q[LAST] <= 1'b0;
            done_q     <= 1'b0;
            retq       <= ret_mask;
            idx        <= IW'(LAST - 1);
            state      <= PS_DOWN;
          end
        end
        PS_DOWN: begin
          bret_q <= bret_q | (bank_hit & retq);
          if (!keep) begin
            en_q[idx] <= 1'b0;
            if (idx == IW'(LLS)) ll_q <= 1'b0;
          end
          if (idx == '0) state <= PS_SLEEP;
          else           idx   <= idx - IW'(1);
        end
        default: begin
          if (go_up) begin
            state  <= PS_UP;
            idx    <= '0;
            skip_q <= en_q;
          end
        end
      endcase
    end
  end

  assign dom_en     = en_q;
  assign bank_ret   = bret_q;
  assign llreg_ok   = ll_q;
  assign chain_done = done_q;
endmodule

// File: rtl/pwr_chain_seq_chk.sv
module pwr_chain_seq_chk #(
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [NB+3:0] dom_en,
  input logic [NB-1:0] bank_ret,
  input logic          llreg_ok,
  input logic          chain_done
);
  localparam int NS = NB + 4;

  p_one_on_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(dom_en & ~$past(dom_en)) <= 1);

  p_order_r2: assert property (@(posedge clk) disable iff (rst)
    (dom_en & ~$past(dom_en) & ~{dom_en[NS-2:0], 1'b1}) == '0);

  p_one_off_r7: assert property (@(posedge clk) disable iff (rst)
    $countones($past(dom_en) & ~dom_en) <= 1);

  p_done_full_r6: assert property (@(posedge clk) disable iff (rst)
    chain_done |-> (&dom_en));

  p_last_first_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(chain_done) |-> !dom_en[NS-1]);

  p_ll_on_r5: assert property (@(posedge clk) disable iff (rst)
    llreg_ok |-> dom_en[1]);

  for (genvar b = 0; b < NB; b++) begin : g_ret
    p_ret_powered_r10: assert property (@(posedge clk) disable iff (rst)
      bank_ret[b] |-> dom_en[b + 2]);
  end
endmodule

bind pwr_chain_seq pwr_chain_seq_chk #(.NB(NB)) u_chk (
  .clk(clk), .rst(rst), .dom_en(dom_en), .bank_ret(bank_ret),
  .llreg_ok(llreg_ok), .chain_done(chain_done)
);

// File: tb/test_pwr_chain_seq.sv
module test_pwr_chain_seq;
  localparam int NB     = 4;
  localparam int NS     = NB + 4;
  localparam int SETTLE = 4;
  localparam int LAT    = 2;
  localparam logic [NS-1:0] RDYM = 8'hC3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sleep_req = 1'b0;
  logic [2:0]    sleep_mode = 3'b000;
  logic          wake = 1'b0;
  logic [NS-1:0] stage_rdy = '0;
  logic [NB-1:0] ret_mask = '0;
  logic          radio_sleep = 1'b1;
  logic [NS-1:0] dom_en;
  logic [NB-1:0] bank_ret;
  logic          llreg_ok, chain_done;

  pwr_chain_seq i_pwr_chain_seq (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .sleep_mode(sleep_mode),
    .wake(wake), .stage_rdy(stage_rdy), .ret_mask(ret_mask),
    .radio_sleep(radio_sleep), .dom_en(dom_en), .bank_ret(bank_ret),
    .llreg_ok(llreg_ok), .chain_done(chain_done)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";
  bit started = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural reference: 0 powering up, 1 complete, 2 powering down, 3 asleep
  int            m_st, m_idx, m_tmr;
  logic [NS-1:0] m_en, m_skip;
  logic [NB-1:0] m_retq, m_bret;
  bit            m_ll, m_done, m_ps, m_pw;

  function automatic bit deep(logic [2:0] m);
    return (m == 3'd2) || (m == 3'd3);
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_st = 0; m_idx = 0; m_tmr = 0; m_en = '0; m_skip = '0;
      m_retq = '0; m_bret = '0; m_ll = 0; m_done = 0; m_ps = 0; m_pw = 0;
    end else begin
      int  st0;
      bit  gd, gu, ok, kp;
      st0 = m_st;
      gd = (st0 == 1) && (m_ps || (sleep_req && deep(sleep_mode)));
      gu = (st0 == 3) && (m_pw || wake);
      if (gd) m_ps = 0; else if (st0 == 0 && sleep_req && deep(sleep_mode)) m_ps = 1;
      if (gu) m_pw = 0; else if (st0 == 2 && wake) m_pw = 1;
      if (st0 == 0) begin
        ok = 0;
        if (m_skip[m_idx]) ok = 1;
        else if (!m_en[m_idx]) begin m_en[m_idx] = 1'b1; m_tmr = 0; end
        else if (RDYM[m_idx]) ok = stage_rdy[m_idx];
        else if (m_tmr == SETTLE - 1) ok = 1;
        else m_tmr++;
        if (ok) begin
          if (m_idx == 1) m_ll = 1;
          if (m_idx == NS - 1) begin m_st = 1; m_done = 1; m_bret = '0; end
          else m_idx++;
        end
      end else if (st0 == 1) begin
        if (gd) begin
          m_en[NS-1] = 1'b0; m_done = 0; m_retq = ret_mask;
          m_idx = NS - 2; m_st = 2;
        end
      end else if (st0 == 2) begin
        kp = 0;
        if (m_idx >= 2 && m_idx < 2 + NB && m_retq[m_idx-2]) begin
          kp = 1; m_bret[m_idx-2] = 1'b1;
        end
        if (m_idx == NB + 2 && !radio_sleep) kp = 1;
        if (!kp) begin m_en[m_idx] = 1'b0; if (m_idx == 1) m_ll = 0; end
        if (m_idx == 0) m_st = 3; else m_idx--;
      end else begin
        if (gu) begin m_st = 0; m_idx = 0; m_skip = m_en; end
      end
    end
  end

  // domain ready model, per-cycle comparison, rise-time monitor, watchdog
  int rdy_cnt [NS];
  int rise_at [NS];
  logic [NS-1:0] prev_en = '0;

  initial for (int k = 0; k < NS; k++) begin rdy_cnt[k] = 0; rise_at[k] = -1; end

  always @(negedge clk) begin
    cyc++;
    if (started) begin
      chk(cur_req, "dom_en", 32'(dom_en), 32'(m_en));
      chk(cur_req, "bank_ret", 32'(bank_ret), 32'(m_bret));
      chk(cur_req, "llreg_ok", 32'(llreg_ok), 32'(m_ll));
      chk(cur_req, "chain_done", 32'(chain_done), 32'(m_done));
      for (int k = 0; k < NS; k++) begin
        if (dom_en[k] && !prev_en[k] && rise_at[k] < 0) rise_at[k] = cyc;
      end
      prev_en = dom_en;
    end
    for (int k = 0; k < NS; k++) begin
      rdy_cnt[k] = m_en[k] ? rdy_cnt[k] + 1 : 0;
      stage_rdy[k] = RDYM[k] && (rdy_cnt[k] >= LAT);
    end
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 300 && !chain_done; i++) @(negedge clk);
  endtask

  task automatic pulse_sleep(logic [2:0] mode);
    sleep_mode = mode; sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
  endtask

  task automatic pulse_wake();
    wake = 1'b1;
    @(negedge clk); wake = 1'b0;
  endtask

  initial begin
    cycles(3);
    chk("R1", "reset dom_en", 32'(dom_en), 0);
    chk("R1", "reset flags", {bank_ret, llreg_ok, chain_done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "first stage after reset", 32'(dom_en), 1);

    cur_req = "R2 R3 R4 R5 R6";
    wait_done();
    chk("R6", "chain complete", {chain_done, dom_en}, {1'b1, 8'hFF});
    chk("R5", "low-leakage ready", 32'(llreg_ok), 1);
    chk("R4", "bank0 to bank1 spacing", 32'(rise_at[3] - rise_at[2]), SETTLE + 1);
    chk("R3", "regulator to bank0 spacing", 32'(rise_at[2] - rise_at[1]), LAT + 1);

    cur_req = "R8";
    pulse_sleep(3'b000); cycles(3);
    pulse_sleep(3'b001); cycles(3);
    pulse_sleep(3'b111); cycles(10);
    chk("R8", "light sleep ignored", {chain_done, dom_en}, {1'b1, 8'hFF});

    cur_req = "R7";
    ret_mask = '0; radio_sleep = 1'b1;
    pulse_sleep(3'b010);
    chk("R7", "nvm off first", 32'(dom_en), 32'h7F);
    cycles(12);
    chk("R7", "all off", {chain_done, llreg_ok, dom_en}, 0);

    cur_req = "R12";
    pulse_wake(); wait_done();
    chk("R12", "wake restarts chain", 32'(chain_done), 1);

    cur_req = "R10 R11";
    ret_mask = 4'b0101; radio_sleep = 1'b0;
    pulse_sleep(3'b011); cycles(12);
    chk("R10", "retained banks and radio stay on", 32'(dom_en), 32'h54);
    chk("R10", "retention flags", 32'(bank_ret), 32'h5);
    pulse_wake(); wait_done();
    chk("R11", "chain complete after skip wake", {chain_done, dom_en}, {1'b1, 8'hFF});
    chk("R10", "retention cleared", 32'(bank_ret), 0);

    cur_req = "R9";
    ret_mask = '0; radio_sleep = 1'b1;
    pulse_sleep(3'b010); cycles(12);
    pulse_wake(); cycles(3);
    pulse_sleep(3'b010);
    chk("R9", "held request, chain not complete", 32'(chain_done), 0);
    wait_done();
    chk("R9", "chain completes before power-down", 32'(dom_en), 32'hFF);
    cycles(14);
    chk("R9", "held power-down executed", 32'(dom_en), 0);

    cur_req = "R12";
    pulse_wake(); wait_done();
    pulse_sleep(3'b010); cycles(2);
    pulse_wake(); cycles(2);
    wait_done();
    chk("R12", "wake during power-down served", {chain_done, dom_en}, {1'b1, 8'hFF});
    cycles(5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule